// File: doc/BRIEF.md
# Power-Fail Self-Refresh Sequencer

This block sits on the controller side of a DDR SDRAM memory subsystem. It parks the memory array in self-refresh when the reset and clock unit reports that power is failing. The reset unit raises a power-fail request. The sequencer accepts it only while it is idle. At that moment it pulses a strobe that tells the posted write buffer to drop its contents, so no buffered data goes to memory. It then waits for the transaction engine to report that all in-flight work has drained.

Once the engine is quiet, the block issues one precharge-all to every rank together. It counts out the precharge time tRP, then enters self-refresh one rank at a time on consecutive memory clocks. Each rank's clock-enable falls in the cycle of its own entry command and stays low. When the last rank is in self-refresh, the block raises a done level to the reset unit. It then ignores everything until the reset unit resets it, which returns it to idle.

The tRP wait length (`TRP_CYC`, default 3 clocks, at least 2) and the rank count (`RANKS`, default 2) are parameters. Command outputs are decoded from registered state.

Top module: `pf_selfref_seq`

## Requirements
- R1: While reset is asserted and after it, before any request, the outputs are: cmd_cs_n_o all ones, ras/cas/we = 1/1/1, cmd_a10_o = 0, cke_o all ones, wbuf_discard_o = 0, pf_done_o = 0.
- R2: A request sampled while idle is accepted. wbuf_discard_o is high for exactly one cycle, the cycle after the accepting clock edge, and the outputs otherwise stay idle.
- R3: After acceptance, no command is issued while eng_idle_i is low. The precharge-all appears in the cycle after the first edge that samples eng_idle_i high.
- R4: Precharge-all is encoded as cmd_cs_n_o = all zeros, ras/cas/we = 0/1/0, cmd_a10_o = 1, cke_o all ones, and lasts exactly one cycle.
- R5: Self-refresh entry to rank 0 comes exactly TRP_CYC cycles after the precharge-all cycle; the cycles between are deselect (cs_n all ones, ras/cas/we = 1/1/1). Self-refresh is encoded as ras/cas/we = 0/0/1 with only the target rank's cs_n bit low (rank 0 = bit 0: cmd_cs_n_o = 2'b10) and that rank's cke bit low in the same cycle (cke_o = 2'b10).
- R6: Ranks enter self-refresh one per cycle in ascending order. Rank 1 follows rank 0 on the next clock with cmd_cs_n_o = 2'b01 and cke_o = 2'b00. Two ranks are never selected together.
- R7: In the cycle after the last rank's entry, pf_done_o rises. From then until reset, pf_done_o stays high, cke_o stays all zeros, and the command is deselect.
- R8: A request that arrives while draining, sequencing or done is ignored: it produces no second discard pulse and does not restart or alter the sequence.
- R9: Asserting rst_n low at any point, including mid-sequence, returns the outputs to the R1 values, and a new request then runs the full sequence again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Active-low reset from the reset unit, asynchronous assert, synchronous release |
| pf_req_i | input | 1 | Power-fail request from the reset unit |
| eng_idle_i | input | 1 | Transaction engine has drained and is idle |
| cmd_cs_n_o | output | RANKS | Per-rank chip selects, active low |
| cmd_ras_n_o | output | 1 | Row strobe, active low |
| cmd_cas_n_o | output | 1 | Column strobe, active low |
| cmd_we_n_o | output | 1 | Write enable, active low |
| cmd_a10_o | output | 1 | Address bit 10, high selects all banks on precharge |
| cke_o | output | RANKS | Per-rank clock enables |
| wbuf_discard_o | output | 1 | One-cycle strobe telling the posted write buffer to drop its data |
| pf_done_o | output | 1 | Sequence complete, held until reset |

## Verification
The bound checker watches several properties on every cycle. It checks that the discard strobe is a single pulse that never coincides with done, and that a precharge-all always carries A10 high with every rank selected. It checks that self-refresh selects exactly one rank, that rank entries step upward on consecutive clocks, that the first entry lands exactly TRP_CYC cycles after the precharge, that clock-enables only ever fall, and that done is sticky with every rank's clock-enable low. Some behaviours only the bench scenarios can show:
- the reset values;
- the dependence of the precharge on the drain indication;
- that late requests leave the sequence untouched;
- that a reset in the middle of the tRP wait gives a clean restart.

// File: rtl/pf_seq_pkg.sv
package pf_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_DRAIN  = 3'd1,
    ST_PREALL = 3'd2,
    ST_TRP    = 3'd3,
    ST_SREF   = 3'd4,
    ST_DONE   = 3'd5
  } pf_state_e;

  // row/column/write strobe triple, active low
  localparam logic [2:0] RCW_DESEL = 3'b111;
  localparam logic [2:0] RCW_PRE   = 3'b010;
  localparam logic [2:0] RCW_SREF  = 3'b001;

endpackage

// File: rtl/pf_trp_timer.sv
module pf_trp_timer #(
  parameter int TRP_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic en_i,
  output logic expire_o
);
  localparam int CW = (TRP_CYC > 2) ? $clog2(TRP_CYC) : 1;
  localparam logic [CW-1:0] LOAD_VAL = CW'(TRP_CYC - 1);
  localparam logic [CW-1:0] ONE      = CW'(1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (load_i) begin
      cnt_en = 1'b1;
      cnt_d  = LOAD_VAL;
    end else if (en_i && (cnt_q != '0)) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expire_o = en_i && (cnt_q == ONE);

endmodule

// File: rtl/pf_seq_fsm.sv
module pf_seq_fsm
  import pf_seq_pkg::*;
#(
  parameter int RANKS = 2,
  localparam int RW = (RANKS > 1) ? $clog2(RANKS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pf_req_i,
  input  logic          eng_idle_i,
  input  logic          tmr_expire_i,
  output pf_state_e     state_o,
  output logic [RW-1:0] rank_o,
  output logic          tmr_load_o,
  output logic          tmr_en_o,
  output logic          discard_o
);
  localparam logic [RW-1:0] LAST_RANK = RW'(RANKS - 1);
  localparam logic [RW-1:0] ONE       = RW'(1);

  pf_state_e     state_q, state_d;
  logic [RW-1:0] rank_q, rank_d;
  logic          rank_en;
  logic          discard_q, discard_d;

  always_comb begin
    state_d    = state_q;
    rank_d     = rank_q;
    rank_en    = 1'b0;
    discard_d  = 1'b0;
    tmr_load_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (pf_req_i) begin
          state_d   = ST_DRAIN;
          discard_d = 1'b1;
        end
      end
      ST_DRAIN: begin
        if (eng_idle_i) state_d = ST_PREALL;
      end
      ST_PREALL: begin
        state_d    = ST_TRP;
        tmr_load_o = 1'b1;
        rank_d     = '0;
        rank_en    = 1'b1;
      end
      ST_TRP: begin
        if (tmr_expire_i) state_d = ST_SREF;
      end
      ST_SREF: begin
        if (rank_q == LAST_RANK) begin
          state_d = ST_DONE;
        end else begin
          rank_d  = rank_q + ONE;
          rank_en = 1'b1;
        end
      end
      ST_DONE: state_d = ST_DONE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      discard_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      discard_q <= discard_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rank_q <= '0;
    else if (rank_en) rank_q <= rank_d;
  end

  assign state_o   = state_q;
  assign rank_o    = rank_q;
  assign tmr_en_o  = (state_q == ST_TRP);
  assign discard_o = discard_q;

endmodule

// File: rtl/pf_cmd_drive.sv
module pf_cmd_drive
  import pf_seq_pkg::*;
#(
  parameter int RANKS = 2,
  localparam int RW = (RANKS > 1) ? $clog2(RANKS) : 1
) (
  input  pf_state_e        state_i,
  input  logic [RW-1:0]    rank_i,
  output logic [RANKS-1:0] cs_n_o,
  output logic             ras_n_o,
  output logic             cas_n_o,
  output logic             we_n_o,
  output logic             a10_o,
  output logic [RANKS-1:0] cke_o,
  output logic             done_o
);
  logic [2:0] rcw;

  always_comb begin
    unique case (state_i)
      ST_PREALL: rcw = RCW_PRE;
      ST_SREF:   rcw = RCW_SREF;
      default:   rcw = RCW_DESEL;
    endcase
  end

  assign {ras_n_o, cas_n_o, we_n_o} = rcw;
  assign a10_o  = (state_i == ST_PREALL);
  assign done_o = (state_i == ST_DONE);

  for (genvar r = 0; r < RANKS; r++) begin : g_rank
    localparam logic [RW-1:0] RIDX = RW'(r);
    logic hit, parked;
    assign hit    = (state_i == ST_SREF) && (rank_i == RIDX);
    assign parked = (state_i == ST_DONE) ||
                    ((state_i == ST_SREF) && (rank_i >= RIDX));
    assign cs_n_o[r] = !((state_i == ST_PREALL) || hit);
    assign cke_o[r]  = !parked;
  end

endmodule

// File: rtl/pf_selfref_seq.sv
module pf_selfref_seq
  import pf_seq_pkg::*;
#(
  parameter int TRP_CYC = 3,
  parameter int RANKS   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pf_req_i,
  input  logic             eng_idle_i,
  output logic [RANKS-1:0] cmd_cs_n_o,
  output logic             cmd_ras_n_o,
  output logic             cmd_cas_n_o,
  output logic             cmd_we_n_o,
  output logic             cmd_a10_o,
  output logic [RANKS-1:0] cke_o,
  output logic             wbuf_discard_o,
  output logic             pf_done_o
);
  localparam int RW = (RANKS > 1) ? $clog2(RANKS) : 1;

  pf_state_e     state;
  logic [RW-1:0] rank;
  logic          tmr_load, tmr_en, tmr_expire;

  pf_seq_fsm #(.RANKS(RANKS)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .pf_req_i     (pf_req_i),
    .eng_idle_i   (eng_idle_i),
    .tmr_expire_i (tmr_expire),
    .state_o      (state),
    .rank_o       (rank),
    .tmr_load_o   (tmr_load),
    .tmr_en_o     (tmr_en),
    .discard_o    (wbuf_discard_o)
  );

  pf_trp_timer #(.TRP_CYC(TRP_CYC)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (tmr_load),
    .en_i     (tmr_en),
    .expire_o (tmr_expire)
  );

  pf_cmd_drive #(.RANKS(RANKS)) u_drv (
    .state_i (state),
    .rank_i  (rank),
    .cs_n_o  (cmd_cs_n_o),
    .ras_n_o (cmd_ras_n_o),
    .cas_n_o (cmd_cas_n_o),
    .we_n_o  (cmd_we_n_o),
    .a10_o   (cmd_a10_o),
    .cke_o   (cke_o),
    .done_o  (pf_done_o)
  );

endmodule

// File: rtl/pf_seq_chk.sv
module pf_seq_chk #(
  parameter int TRP_CYC = 3,
  parameter int RANKS   = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pf_req_i,
  input logic [RANKS-1:0] cmd_cs_n_o,
  input logic             cmd_ras_n_o,
  input logic             cmd_cas_n_o,
  input logic             cmd_we_n_o,
  input logic             cmd_a10_o,
  input logic [RANKS-1:0] cke_o,
  input logic             wbuf_discard_o,
  input logic             pf_done_o
);
  localparam int GW = $clog2(TRP_CYC + 2) + 1;
  localparam logic [GW-1:0] GSAT = GW'(TRP_CYC + 1);

  logic is_pre, is_sref;
  logic [GW-1:0] gap_q;

  assign is_pre  = !cmd_ras_n_o &&  cmd_cas_n_o && !cmd_we_n_o;
  assign is_sref = !cmd_ras_n_o && !cmd_cas_n_o &&  cmd_we_n_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            gap_q <= '0;
    else if (is_pre)                       gap_q <= GW'(1);
    else if (gap_q != '0 && gap_q < GSAT)  gap_q <= gap_q + GW'(1);
  end

  // R2
  discard_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wbuf_discard_o |=> !wbuf_discard_o);

  // R8
  no_discard_when_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pf_done_o |-> !wbuf_discard_o);

  // R4
  preall_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_pre |-> (cmd_a10_o && cmd_cs_n_o == '0 && cke_o == '1));

  // R4
  preall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_pre |=> !is_pre);

  // R6
  sref_one_rank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_sref |-> $onehot(~cmd_cs_n_o));

  // R6
  sref_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_sref && cmd_cs_n_o[RANKS-1]) |=>
      (is_sref && (~cmd_cs_n_o == ($past(~cmd_cs_n_o) << 1))));

  // R5
  trp_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_sref && !cmd_cs_n_o[0]) |-> (gap_q == GW'(TRP_CYC)));

  // R7
  cke_fall_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cke_o & ~$past(cke_o)) == '0);

  // R7
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pf_done_o |=> pf_done_o);

  // R7
  done_parked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pf_done_o |-> (cke_o == '0 && cmd_cs_n_o == '1));

endmodule

bind pf_selfref_seq pf_seq_chk #(.TRP_CYC(TRP_CYC), .RANKS(RANKS)) u_chk (.*);

// File: tb/sim_pf_selfref_seq.sv
`timescale 1ns/1ps
module sim_pf_selfref_seq;
  localparam int TRP = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pf_req = 1'b0;
  logic eng_idle = 1'b0;
  logic [1:0] cs_n, cke;
  logic ras_n, cas_n, we_n, a10, discard, done;

  int checks = 0;
  int errors = 0;

  logic [9:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  pf_selfref_seq #(.TRP_CYC(TRP), .RANKS(2)) u0 (
    .clk(clk), .rst_n(rst_n), .pf_req_i(pf_req), .eng_idle_i(eng_idle),
    .cmd_cs_n_o(cs_n), .cmd_ras_n_o(ras_n), .cmd_cas_n_o(cas_n),
    .cmd_we_n_o(we_n), .cmd_a10_o(a10), .cke_o(cke),
    .wbuf_discard_o(discard), .pf_done_o(done)
  );

  // {cs_n[1:0], ras, cas, we, a10, cke[1:0], discard, done}
  function automatic logic [9:0] ev(logic [1:0] c, logic [2:0] rcw, logic a,
                                    logic [1:0] k, logic d, logic f);
    return {c, rcw, a, k, d, f};
  endfunction

  localparam logic [9:0] E_IDLE = {2'b11, 3'b111, 1'b0, 2'b11, 1'b0, 1'b0};
  localparam logic [9:0] E_DISC = {2'b11, 3'b111, 1'b0, 2'b11, 1'b1, 1'b0};
  localparam logic [9:0] E_PRE  = {2'b00, 3'b010, 1'b1, 2'b11, 1'b0, 1'b0};
  localparam logic [9:0] E_SR0  = {2'b10, 3'b001, 1'b0, 2'b10, 1'b0, 1'b0};
  localparam logic [9:0] E_SR1  = {2'b01, 3'b001, 1'b0, 2'b00, 1'b0, 1'b0};
  localparam logic [9:0] E_DONE = {2'b11, 3'b111, 1'b0, 2'b00, 1'b0, 1'b1};

  function automatic logic [9:0] actual();
    return {cs_n, ras_n, cas_n, we_n, a10, cke, discard, done};
  endfunction

  task automatic check(logic [9:0] act, logic [9:0] exp, string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // driver: set inputs for the next edge, queue the outputs expected after it
  task automatic step(logic req, logic idl, logic [9:0] exp, string tag);
    @(negedge clk);
    pf_req   = req;
    eng_idle = idl;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) check(actual(), exp_q.pop_front(), tag_q.pop_front());
    end
  end

  task automatic drain_queue();
    while (exp_q.size() > 0) @(posedge clk);
    #3;
  endtask

  task automatic do_reset(string tag);
    drain_queue();
    @(negedge clk);
    rst_n = 1'b0;
    pf_req = 1'b1;
    #1;
    check(actual(), E_IDLE, tag);
    repeat (2) @(negedge clk);
    pf_req = 1'b0;
    rst_n = 1'b1;
  endtask

  // full sequence from an accepted request onward, drain given by wait cycles
  task automatic run_seq(int drain_wait, logic noisy);
    step(1'b1, 1'b0, E_DISC, "R2 discard pulse on accept");
    for (int i = 0; i < drain_wait; i++)
      step(noisy, 1'b0, E_IDLE, "R3/R8 hold while draining");
    step(1'b0, 1'b1, E_PRE, "R4 precharge-all");
    for (int i = 0; i < TRP - 1; i++)
      step(noisy, 1'b1, E_IDLE, "R5 deselect during tRP");
    step(1'b0, 1'b1, E_SR0, "R5 self-refresh rank 0");
    step(noisy, 1'b0, E_SR1, "R6 self-refresh rank 1");
    for (int i = 0; i < 4; i++)
      step(noisy, 1'b0, E_DONE, "R7/R8 done held");
  endtask

  initial begin
    #1;
    check(actual(), E_IDLE, "R1 reset values");
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    step(1'b0, 1'b0, E_IDLE, "R1 idle after reset");
    step(1'b0, 1'b1, E_IDLE, "R1 idle with engine idle");
    run_seq(3, 1'b1);
    do_reset("R9 reset from done");

    step(1'b0, 1'b0, E_IDLE, "R9 idle after reset");
    run_seq(0, 1'b0);
    do_reset("R9 reset from done again");

    // interrupt during the tRP wait, then rerun cleanly
    step(1'b1, 1'b1, E_DISC, "R2 accept with engine idle");
    step(1'b0, 1'b1, E_PRE,  "R3 precharge right after drain");
    step(1'b0, 1'b1, E_IDLE, "R5 tRP wait");
    do_reset("R9 reset during tRP");
    step(1'b0, 1'b1, E_IDLE, "R9 no leftover command");
    run_seq(1, 1'b1);

    drain_queue();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule